// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM

This block produces the address, operation type, byte-write mask and data-bus drive enable for a synchronous SRAM port that runs bursts of up to four beats from one supplied address. Each clock edge is either a load or an advance, chosen by a single control input. A load captures a full starting address together with the select and write request. An advance steps an internal beat counter that rewrites only the two lowest address bits, and keeps the operation type captured at load time.

Two burst orderings are available through a static order input. The interleaved order XORs the starting low bits with the beat count. The linear order adds the beat count to the starting low bits and wraps modulo four. The byte-write mask is sampled again on every edge, so each beat of a write burst can write a different set of bytes. The data-bus drive enable follows the caller's output-enable request on read beats and is held off on every write beat.

Top module: `burst_seq_top`

## Requirements
- R1: On an edge with `advance`=0, the next cycle shows `addr_out` equal to the sampled `addr_in`, `access_vld` equal to the sampled `sel_in`, and `access_wr` equal to the sampled `sel_in & wr_in`.
- R2: Advance edges never change `addr_out` bits above bit 1.
- R3: On advance edges `sel_in` and `wr_in` are ignored: `access_vld` and `access_wr` keep the values from the last load.
- R4: With `order_sel`=1 (interleaved), beat k of a burst that starts at low bits s has low bits s XOR k, for example 11,10,01,00 from 11.
- R5: With `order_sel`=0 (linear), beat k has low bits (s + k) mod 4, for example 01,10,11,00 from 01.
- R6: Advance edges after the fourth beat wrap the beat count, so the fifth beat repeats the starting low bits.
- R7: During a write access, `bmask_out` equals the `bmask_in` sampled at the edge that started that beat, with bit i selecting byte i. Outside write accesses `bmask_out` is zero.
- R8: `bus_drive_en` is 1 only when `access_vld`=1, `access_wr`=0 and `oe_req`=1. It stays 0 on every write beat whatever `oe_req` is.
- R9: Until the first load with `sel_in`=1 after reset, advance edges give `access_vld`=0 and `bus_drive_en`=0.
- R10: During and just after reset, `addr_out`, `access_vld`, `access_wr`, `bmask_out` and `bus_drive_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | 0 = load a new address and operation, 1 = advance the burst |
| addr_in | input | ADDR_W | Starting address, sampled on load edges |
| sel_in | input | 1 | Access request, sampled on load edges |
| wr_in | input | 1 | 1 = write, 0 = read, sampled on load edges |
| order_sel | input | 1 | Static order select: 1 = interleaved, 0 = linear |
| bmask_in | input | BYTES | Byte-write mask, sampled on every edge |
| oe_req | input | 1 | Output-enable request for read data |
| addr_out | output | ADDR_W | Address of the current beat |
| access_vld | output | 1 | An access is in progress this beat |
| access_wr | output | 1 | The current access is a write |
| bmask_out | output | BYTES | Byte-write mask for the current beat |
| bus_drive_en | output | 1 | Enable for the data-bus output drivers |

## Verification
The embedded properties check on every cycle that advances keep the upper address bits and the latched operation, and that the low bits step the right way for each order: the lowest bit toggles when interleaved, and the low bits go up by one when linear. They also hold the drive enable off on write beats and when output-enable is low, and tie the write mask to the previous edge's input. Only the directed scenarios can show the full four-beat sequence from each starting value in both orders, the wrap on the fifth beat, the inactive state before any load, and per-beat masks that differ across one write burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   typedef struct packed {
      logic act;
      logic wr;
   } op_t;

   localparam op_t OP_IDLE = '{act: 1'b0, wr: 1'b0};

endpackage

// File: rtl/bseq_capture.sv
module bseq_capture
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              sel_in,
   input  logic              wr_in,
   output logic [ADDR_W-1:0] base_q,
   output logic [BEAT_W-1:0] beat_q,
   output op_t               op_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
         op_q   <= OP_IDLE;
      end else if (!advance) begin
         base_q <= addr_in;
         beat_q <= '0;
         op_q   <= '{act: sel_in, wr: sel_in & wr_in};
      end else begin
         beat_q <= beat_q + 1'b1;
      end
   end

   // R2
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> base_q == $past(base_q));

   // R3
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> op_q == $past(op_q));

endmodule

// File: rtl/bseq_order.sv
module bseq_order
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              order_sel,
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] beat,
   output logic [BEAT_W-1:0] cur_lo
);

   logic [BEAT_W-1:0] xor_lo;
   logic [BEAT_W-1:0] add_lo;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
      assign xor_lo[b] = start_lo[b] ^ beat[b];
   end

   assign add_lo = start_lo + beat;
   assign cur_lo = (order_e'(order_sel) == ORD_INTERLEAVE) ? xor_lo : add_lo;

   // R4
   ilv_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance && order_sel |=> !order_sel || (cur_lo[0] != $past(cur_lo[0])));

   // R5
   lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !order_sel |=> order_sel || (cur_lo == $past(cur_lo) + 1'b1));

endmodule

// File: rtl/bseq_drive.sv
module bseq_drive
   import burst_seq_pkg::*;
#(
   parameter int BYTES = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BYTES-1:0] bmask_in,
   input  op_t              op,
   input  logic             oe_req,
   output logic [BYTES-1:0] bmask_out,
   output logic             bus_drive_en
);

   logic [BYTES-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= bmask_in;
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign bmask_out[i] = mask_q[i] & op.wr;
   end

   assign bus_drive_en = op.act & ~op.wr & oe_req;

   // R7
   mask_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op.wr |-> bmask_out == $past(bmask_in));

   // R8
   wr_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op.wr |-> !bus_drive_en);

   // R8
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_req |-> !bus_drive_en);

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BYTES  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              sel_in,
   input  logic              wr_in,
   input  logic              order_sel,
   input  logic [BYTES-1:0]  bmask_in,
   input  logic              oe_req,
   output logic [ADDR_W-1:0] addr_out,
   output logic              access_vld,
   output logic              access_wr,
   output logic [BYTES-1:0]  bmask_out,
   output logic              bus_drive_en
);

   localparam int BEAT_W = 2;

   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("ADDR_W must exceed the burst bit count");
   end
   if (BYTES < 1) begin : g_bad_bytes
      $error("BYTES must be at least 1");
   end

   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] cur_lo;
   op_t               op_q;

   bseq_capture #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .advance(advance), .addr_in(addr_in),
      .sel_in(sel_in), .wr_in(wr_in), .base_q(base_q), .beat_q(beat_q),
      .op_q(op_q)
   );

   bseq_order #(.BEAT_W(BEAT_W)) u_ord (
      .clk(clk), .rst_n(rst_n), .advance(advance), .order_sel(order_sel),
      .start_lo(base_q[BEAT_W-1:0]), .beat(beat_q), .cur_lo(cur_lo)
   );

   bseq_drive #(.BYTES(BYTES)) u_drv (
      .clk(clk), .rst_n(rst_n), .bmask_in(bmask_in), .op(op_q),
      .oe_req(oe_req), .bmask_out(bmask_out), .bus_drive_en(bus_drive_en)
   );

   assign addr_out   = {base_q[ADDR_W-1:BEAT_W], cur_lo};
   assign access_vld = op_q.act;
   assign access_wr  = op_q.wr;

   // R1
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> addr_out == $past(addr_in) && access_vld == $past(sel_in)
                   && access_wr == $past(sel_in & wr_in));

   // R2
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/tb_burst_seq_top.sv
module tb_burst_seq_top;

   localparam int ADDR_W = 20;
   localparam int BYTES  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              advance = 1'b0;
   logic [ADDR_W-1:0] addr_in = '0;
   logic              sel_in = 1'b0;
   logic              wr_in = 1'b0;
   logic              order_sel = 1'b1;
   logic [BYTES-1:0]  bmask_in = '0;
   logic              oe_req = 1'b0;
   logic [ADDR_W-1:0] addr_out;
   logic              access_vld;
   logic              access_wr;
   logic [BYTES-1:0]  bmask_out;
   logic              bus_drive_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_seq_top #(.ADDR_W(ADDR_W), .BYTES(BYTES)) dut (
      .clk(clk), .rst_n(rst_n), .advance(advance), .addr_in(addr_in),
      .sel_in(sel_in), .wr_in(wr_in), .order_sel(order_sel),
      .bmask_in(bmask_in), .oe_req(oe_req), .addr_out(addr_out),
      .access_vld(access_vld), .access_wr(access_wr),
      .bmask_out(bmask_out), .bus_drive_en(bus_drive_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive on the falling edge, let one rising edge pass, sample 1 ns later
   task automatic step(input logic adv, input logic [ADDR_W-1:0] a,
                       input logic s, input logic w, input logic [BYTES-1:0] m);
      @(negedge clk);
      advance = adv; addr_in = a; sel_in = s; wr_in = w; bmask_in = m;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [1:0] exp_lo(input logic ilv, input logic [1:0] s, input int k);
      logic [1:0] kk = k[1:0];
      return ilv ? (s ^ kk) : (s + kk);
   endfunction

   task automatic t_reset;
      chk("R10 addr", 32'(addr_out), 0);
      chk("R10 vld", 32'(access_vld), 0);
      chk("R10 wr", 32'(access_wr), 0);
      chk("R10 mask", 32'(bmask_out), 0);
      chk("R10 drive", 32'(bus_drive_en), 0);
   endtask

   task automatic t_no_load;
      oe_req = 1'b1;
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 20'h12345, 1'b1, 1'b0, 4'hF);
         chk("R9 vld before load", 32'(access_vld), 0);
         chk("R9 drive before load", 32'(bus_drive_en), 0);
      end
   endtask

   task automatic t_order(input logic ilv);
      logic [ADDR_W-1:0] base;
      oe_req = 1'b1;
      for (int s = 0; s < 4; s++) begin
         @(negedge clk); order_sel = ilv;
         base = 20'hA5C30 | ADDR_W'(s);
         step(1'b0, base, 1'b1, 1'b0, 4'h0);
         chk("R1 load addr", 32'(addr_out), 32'(base));
         chk("R1 load vld", 32'(access_vld), 1);
         chk("R8 read drive", 32'(bus_drive_en), 1);
         for (int k = 1; k <= 5; k++) begin
            step(1'b1, 20'h00000, 1'b0, 1'b1, 4'h0);
            chk(ilv ? "R4 interleaved low" : "R5 linear low",
                32'(addr_out[1:0]), 32'(exp_lo(ilv, 2'(s), k)));
            chk("R2 upper", 32'(addr_out[ADDR_W-1:2]), 32'(base[ADDR_W-1:2]));
            if (k == 4)
               chk("R6 wrap", 32'(addr_out[1:0]), 32'(s));
            chk("R3 vld kept", 32'(access_vld), 1);
            chk("R3 read kept", 32'(access_wr), 0);
         end
      end
   endtask

   task automatic t_write;
      logic [BYTES-1:0] masks [4] = '{4'h1, 4'hC, 4'h0, 4'hA};
      oe_req = 1'b1;
      @(negedge clk); order_sel = 1'b0;
      step(1'b0, 20'h7FFF2, 1'b1, 1'b1, masks[0]);
      chk("R1 write", 32'(access_wr), 1);
      chk("R7 mask beat0", 32'(bmask_out), 32'(masks[0]));
      chk("R8 write tristate", 32'(bus_drive_en), 0);
      for (int k = 1; k < 4; k++) begin
         step(1'b1, 20'h0, 1'b0, 1'b0, masks[k]);
         chk("R3 write kept", 32'(access_wr), 1);
         chk("R7 mask per beat", 32'(bmask_out), 32'(masks[k]));
         chk("R8 write tristate", 32'(bus_drive_en), 0);
         chk("R5 linear write low", 32'(addr_out[1:0]), 32'(exp_lo(1'b0, 2'b10, k)));
      end
   endtask

   task automatic t_read_oe;
      step(1'b0, 20'h00401, 1'b1, 1'b0, 4'hF);
      chk("R7 read mask zero", 32'(bmask_out), 0);
      @(negedge clk); oe_req = 1'b0; #1;
      chk("R8 oe off", 32'(bus_drive_en), 0);
      @(negedge clk); oe_req = 1'b1; #1;
      chk("R8 oe on", 32'(bus_drive_en), 1);
   endtask

   task automatic t_deselect;
      step(1'b0, 20'h3C3C3, 1'b0, 1'b1, 4'hF);
      chk("R1 deselect vld", 32'(access_vld), 0);
      chk("R1 deselect wr", 32'(access_wr), 0);
      chk("R1 deselect drive", 32'(bus_drive_en), 0);
      step(1'b1, 20'h0, 1'b1, 1'b0, 4'hF);
      chk("R3 advance keeps idle", 32'(access_vld), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_no_load();
      t_order(1'b1);
      t_order(1'b0);
      t_write();
      t_read_oe();
      t_deselect();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule